// File: doc/BRIEF.md
# Tiered Daisy-Chain Bus Arbiter

This block decides which device on a shared bus becomes its owner. Devices are grouped into priority tiers. Each tier has its own grant chain of device slots. Every tier offers the grant to the slot nearest the arbiter. A slot with a pending request keeps the grant. A slot without one hands the grant to the next slot along the chain. The tier whose grant is taken first in priority order wins. Its winning slot receives a registered, one-hot grant.

Once a device owns the bus, the block keeps the grant on that device for as long as it holds its request. It ignores every other request in that time, even one from a higher tier. When the owner lowers its request, the grant is withdrawn and the bus reads idle for one cycle. After that, arbitration runs again among whatever requests are pending. Device slots are numbered `tier * TIER_SLOTS + slot`. Tier 0 is the most urgent tier, and slot 0 is the slot nearest the arbiter.

Top module: `tiered_chain_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `dev_grant` all zero, `bus_busy` low and `owner_id` zero.
- R2: The grant is registered. While the bus is idle, a request present at a rising edge produces a grant right after that edge. Nothing appears on `dev_grant` in the cycle the request is first driven.
- R3: When the bus is idle and requests are pending in several tiers, the winner comes from the lowest-numbered tier that has a request. Tier 0 wins over every other tier.
- R4: Within the winning tier, the requesting slot with the lowest slot number (the one nearest the arbiter) wins over farther requesting slots.
- R5: Slots without a request pass the grant along their chain. A lone request at the far end of a chain (slot `TIER_SLOTS-1`) is granted.
- R6: While the owner keeps its request high, `dev_grant` and `owner_id` hold their values. New requests from other devices, including devices in higher-priority tiers, have no effect.
- R7: At the first rising edge where the owner's request is low, `dev_grant` clears and `bus_busy` falls. A request that is still pending is granted at the next rising edge.
- R8: At most one bit of `dev_grant` is high in any cycle.
- R9: `bus_busy` is high exactly when one grant bit is high. While it is high, `owner_id` holds the index (`tier * TIER_SLOTS + slot`) of the granted device.
- R10: While the bus is idle and no device requests, the bus stays idle and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | PRIO_TIERS*TIER_SLOTS (16) | Per-device request; bit `tier*TIER_SLOTS+slot` |
| dev_grant | output | PRIO_TIERS*TIER_SLOTS (16) | Registered one-hot grant, same bit order as `dev_req` |
| bus_busy | output | 1 | High while a device owns the bus |
| owner_id | output | clog2(PRIO_TIERS*TIER_SLOTS) (4) | Index of the owning device, zero when idle |

## Verification
The bench drives a request from a higher tier while a lower-tier device holds the bus. A design that preempts the owner would move the grant early. The bench also checks the dead cycle after a release and the chain's far slot. A design that re-arbitrates on the release edge would show a new grant one cycle too soon. A chain that stops forwarding after a non-requesting slot would leave the last slot starved. Mixed patterns across tiers and slots, some fixed and some pseudo-random, expose a reversed tier order or slot order by granting the wrong index. Each check also confirms that `owner_id` agrees with the grant and that at most one grant bit is set.

// File: rtl/tca_pkg.sv
package tca_pkg;

  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;

endpackage

// File: rtl/tca_chain_cell.sv
// One device position on a grant chain: keeps the grant when requesting,
// otherwise hands it to the next position.
module tca_chain_cell (
  input  logic req,
  input  logic gnt_in,
  output logic gnt_out,
  output logic take
);

  assign take    = gnt_in & req;
  assign gnt_out = gnt_in & ~req;

endmodule

// File: rtl/tca_level_chain.sv
// A full grant chain for one priority tier. Slot 0 is nearest the arbiter.
module tca_level_chain #(
  parameter int SLOTS = 4
) (
  input  logic             offer,
  input  logic [SLOTS-1:0] req,
  output logic [SLOTS-1:0] take,
  output logic             tier_req
);

  logic [SLOTS:0] link;

  assign link[0] = offer;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    tca_chain_cell u_cell (
      .req    (req[s]),
      .gnt_in (link[s]),
      .gnt_out(link[s+1]),
      .take   (take[s])
    );
  end

  // The tier has a request exactly when an offered grant is absorbed
  // before it runs off the chain end.
  assign tier_req = offer & ~link[SLOTS];

endmodule

// File: rtl/tca_level_pick.sv
// Selects the most urgent tier (lowest index) that has a request.
module tca_level_pick #(
  parameter int TIERS = 4
) (
  input  logic [TIERS-1:0] tier_req,
  output logic [TIERS-1:0] tier_sel
);

  logic found;

  always_comb begin
    tier_sel = '0;
    found    = 1'b0;
    for (int t = 0; t < TIERS; t++) begin
      if (!found && tier_req[t]) begin
        tier_sel[t] = 1'b1;
        found       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tiered_chain_arbiter.sv
module tiered_chain_arbiter #(
  parameter int PRIO_TIERS = 4,
  parameter int TIER_SLOTS = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [PRIO_TIERS*TIER_SLOTS-1:0]          dev_req,
  output logic [PRIO_TIERS*TIER_SLOTS-1:0]          dev_grant,
  output logic                                      bus_busy,
  output logic [$clog2(PRIO_TIERS*TIER_SLOTS)-1:0]  owner_id
);

  import tca_pkg::*;

  localparam int NDEV = PRIO_TIERS * TIER_SLOTS;
  localparam int IDW  = $clog2(NDEV);

  arb_state_e            state_q;
  logic [NDEV-1:0]       grant_q;
  logic [IDW-1:0]        owner_q;

  logic                  offer;
  logic [NDEV-1:0]       chain_take;
  logic [PRIO_TIERS-1:0] tier_req;
  logic [PRIO_TIERS-1:0] tier_sel;
  logic [NDEV-1:0]       win_vec;
  logic [IDW-1:0]        win_idx;
  logic                  owner_holds;

  // Chains are offered the grant only while the bus is free.
  assign offer = (state_q == ARB_IDLE);

  for (genvar t = 0; t < PRIO_TIERS; t++) begin : g_tier
    tca_level_chain #(
      .SLOTS(TIER_SLOTS)
    ) u_chain (
      .offer   (offer),
      .req     (dev_req[t*TIER_SLOTS +: TIER_SLOTS]),
      .take    (chain_take[t*TIER_SLOTS +: TIER_SLOTS]),
      .tier_req(tier_req[t])
    );
    assign win_vec[t*TIER_SLOTS +: TIER_SLOTS] =
      chain_take[t*TIER_SLOTS +: TIER_SLOTS] & {TIER_SLOTS{tier_sel[t]}};
  end

  tca_level_pick #(
    .TIERS(PRIO_TIERS)
  ) u_pick (
    .tier_req(tier_req),
    .tier_sel(tier_sel)
  );

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (win_vec[i]) win_idx = IDW'(i);
    end
  end

  assign owner_holds = |(grant_q & dev_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      owner_q <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (|win_vec) begin
            state_q <= ARB_OWNED;
            grant_q <= win_vec;
            owner_q <= win_idx;
          end
        end
        ARB_OWNED: begin
          if (!owner_holds) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            owner_q <= '0;
          end
        end
        default: begin
          state_q <= ARB_IDLE;
          grant_q <= '0;
          owner_q <= '0;
        end
      endcase
    end
  end

  assign dev_grant = grant_q;
  assign bus_busy  = (state_q == ARB_OWNED);
  assign owner_id  = owner_q;

endmodule

// File: rtl/tiered_chain_arbiter_checker.sv
module tiered_chain_arbiter_checker #(
  parameter int NDEV = 16,
  parameter int IDW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NDEV-1:0] dev_req,
  input logic [NDEV-1:0] dev_grant,
  input logic            bus_busy,
  input logic [IDW-1:0]  owner_id
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_grant)); // R8

  AST_BUSY_MATCHES_GRANT: assert property (@(posedge clk) disable iff (rst)
    bus_busy == ($countones(dev_grant) == 1)); // R9

  AST_OWNER_INDEX: assert property (@(posedge clk) disable iff (rst)
    bus_busy |-> dev_grant[owner_id]); // R9

  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && |(dev_grant & dev_req)) |=> ($stable(dev_grant) && $stable(owner_id))); // R6

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && !(|(dev_grant & dev_req))) |=> (!bus_busy && dev_grant == '0)); // R7

  AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && |dev_req) |=> bus_busy); // R2

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && dev_req == '0) |=> !bus_busy); // R10

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> |(dev_grant & $past(dev_req))); // R2

endmodule

bind tiered_chain_arbiter tiered_chain_arbiter_checker #(
  .NDEV(PRIO_TIERS*TIER_SLOTS),
  .IDW ($clog2(PRIO_TIERS*TIER_SLOTS))
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .dev_req  (dev_req),
  .dev_grant(dev_grant),
  .bus_busy (bus_busy),
  .owner_id (owner_id)
);

// File: tb/tiered_chain_arbiter_bench.sv
module tiered_chain_arbiter_bench;

  localparam int NT   = 4;
  localparam int NS   = 4;
  localparam int NDEV = NT * NS;
  localparam int IDW  = $clog2(NDEV);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NDEV-1:0] dev_req = '0;
  logic [NDEV-1:0] dev_grant;
  logic            bus_busy;
  logic [IDW-1:0]  owner_id;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tiered_chain_arbiter #(.PRIO_TIERS(NT), .TIER_SLOTS(NS)) u_tiered_chain_arbiter (
    .clk      (clk),
    .rst      (rst),
    .dev_req  (dev_req),
    .dev_grant(dev_grant),
    .bus_busy (bus_busy),
    .owner_id (owner_id)
  );

  // Expected winner from the priority rules: lowest tier, then nearest slot.
  function automatic int exp_winner(input logic [NDEV-1:0] r);
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < NS; s++)
        if (r[t*NS+s]) return t*NS + s;
    return -1;
  endfunction

  function automatic logic [NDEV-1:0] onehot(input int i);
    logic [NDEV-1:0] v = '0;
    if (i >= 0) v[i] = 1'b1;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int exp_idx);
    logic [NDEV-1:0] eg = onehot(exp_idx);
    logic            eb = (exp_idx >= 0);
    logic [IDW-1:0]  eo = (exp_idx >= 0) ? IDW'(exp_idx) : '0;
    vectors++;
    if (dev_grant !== eg || bus_busy !== eb || owner_id !== eo ||
        $countones(dev_grant) > 1) begin
      errors++;
      $display("FAIL %s (R8/R9 consistency): grant=%h busy=%b owner=%0d expected grant=%h busy=%b owner=%0d",
               tag, dev_grant, bus_busy, owner_id, eg, eb, eo);
    end
  endtask

  task automatic t_reset();
    check("R1 reset state", -1);
  endtask

  task automatic t_idle();
    dev_req = '0;
    repeat (3) tick();
    check("R10 idle without requests", -1);
  endtask

  task automatic t_far_slot();
    dev_req = onehot(1*NS + NS-1);
    #1;
    check("R2 no grant before edge", -1);
    tick();
    check("R5 far slot granted (R2 one edge)", 1*NS + NS-1);
    dev_req = '0;
    tick();
    check("R7 cleared on release", -1);
  endtask

  task automatic apply(input string tag, input logic [NDEV-1:0] pat);
    dev_req = pat;
    tick();
    check(tag, exp_winner(pat));
    dev_req = '0;
    tick();
    check("R7 back to idle", -1);
  endtask

  task automatic t_tiers();
    apply("R3 tier1 beats tier2", onehot(2*NS+0) | onehot(1*NS+3));
    apply("R3 tier0 beats tier3", onehot(3*NS+0) | onehot(0*NS+2));
    apply("R4 nearest slot in tier2", onehot(2*NS+2) | onehot(2*NS+1));
    apply("R4 slot0 over all of tier3", {NS{1'b1}} << (3*NS));
  endtask

  task automatic t_hold_release();
    dev_req = onehot(3*NS);
    tick();
    check("R6 lower tier owns", 3*NS);
    dev_req = onehot(3*NS) | onehot(0) | onehot(5);
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R6 held against higher tier", 3*NS);
    end
    dev_req = onehot(0) | onehot(5);
    tick();
    check("R7 dead cycle after release", -1);
    tick();
    check("R7 pending request granted", 0);
    dev_req = onehot(5);
    tick();
    check("R7 second release gap", -1);
    tick();
    check("R7 next pending granted", 5);
    dev_req = '0;
    tick();
    check("R7 idle", -1);
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < NDEV; i++) apply("R5 R9 single request", onehot(i));
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply("R3 R4 R9 mixed pattern", NDEV'(lfsr));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_far_slot();
    t_tiers();
    t_hold_release();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule